// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block holds the configuration that a clock synthesizer's divider logic needs: a 9-bit feedback divider value, a 2-bit output divider select and a spread-spectrum enable bit. It drives all three as registered outputs. Two paths can load them. The parallel path takes nine static pins and is gated by an active-low strobe. The serial path is three wires: a data line, a shift clock and a load strobe.

Every strobe and the shift clock are sampled on one fast system clock. Edges are found by comparing each input with its value in the previous cycle, so the whole block lives in a single clock domain. Each output change lands one system clock after the input event that causes it. A one-cycle pulse marks every cycle in which any configuration output changes value. A registered divider-enable output follows the inverse of the active-high master reset, and the master reset leaves the loaded configuration untouched.

Serial frames are 14 shift-clock rises long. The first two slots carry no data but must still be clocked. Then come the spread enable, the two divider-select bits with the upper bit first, and the nine feedback bits with the most significant bit first.

Top module: `synth_cfg_loader`

## Requirements
- R1: While `rst_n` is low, the outputs hold these values: `m_val` = parameter `M_INIT` (200), `n_sel` = 2'b01, `ssc_en` = 0, `div_en` = 0, `cfg_upd` = 0.
- R2: While `p_load_n` is low, `m_val` takes the value of `m_pins` one clock later and `n_sel` is forced to 2'b01.
- R3: After `p_load_n` returns high, `m_val` keeps the last value it passed through, however `m_pins` change.
- R4: A rise of `s_clk` shifts `s_data` into the shift register only while `p_load_n` is high. A frame is 14 bits sent in this order: null, null, spread enable, select bit 1, select bit 0, feedback bits 8 down to 0. The register keeps the last 12 bits shifted in.
- R5: A rise of `s_load` copies the shift register into `m_val`, `n_sel` and `ssc_en` one clock later. If `s_clk` rises in the same clock, the bit shifted in on that clock is part of what is copied.
- R6: While `p_load_n` is high and `s_load` is low, including the clock in which `s_load` falls, the outputs hold even when shifting goes on.
- R7: While `s_load` stays high, each `s_clk` rise copies the updated shift register to the outputs one clock later.
- R8: The `n_sel` encoding is 00 = divide by 1, 01 = divide by 2, 10 = divide by 4, 11 = divide by 8. Only a serial transfer can set a value other than 01.
- R9: `div_en` equals the inverse of `mr`, one clock later. `mr` does not change `m_val`, `n_sel` or `ssc_en`.
- R10: `cfg_upd` is high for exactly the clocks in which `{m_val, n_sel, ssc_en}` differs from its value one clock earlier.
- R11: `s_clk` rises while `p_load_n` is low do not alter the shift register. A later transfer still delivers the earlier contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every other input |
| rst_n | input | 1 | Active-low power-up reset; applies the defaults |
| mr | input | 1 | Active-high master reset of the downstream dividers |
| p_load_n | input | 1 | Active-low parallel-load strobe |
| m_pins | input | 9 | Static feedback divider pins |
| s_clk | input | 1 | Serial shift clock, sampled |
| s_data | input | 1 | Serial data line |
| s_load | input | 1 | Serial transfer strobe |
| m_val | output | 9 | Feedback divider value |
| n_sel | output | 2 | Output divider select |
| ssc_en | output | 1 | Spread-spectrum enable |
| div_en | output | 1 | Divider run enable, low while master reset is applied |
| cfg_upd | output | 1 | One-cycle pulse when any configuration output changes |

## Verification
The last shift-clock rise of a frame and the rise of the transfer strobe can arrive in the same system clock. The design must then shift the final bit and copy the register in one step, so the transferred value includes that bit. The bench sends one frame with that final rise and the strobe rise driven together. It also sends frames in which the strobe rises on a later clock. A reference model predicts both cases from the requirements, and a scoreboard compares every output, including the change pulse, one clock after each stimulus.

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader #(
  parameter int M_W = 9,
  parameter int N_W = 2,
  parameter logic [M_W-1:0] M_INIT = 200
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mr,
  input  logic           p_load_n,
  input  logic [M_W-1:0] m_pins,
  input  logic           s_clk,
  input  logic           s_data,
  input  logic           s_load,
  output logic [M_W-1:0] m_val,
  output logic [N_W-1:0] n_sel,
  output logic           ssc_en,
  output logic           div_en,
  output logic           cfg_upd
);
  localparam int PAY = M_W + N_W + 1;
  localparam logic [N_W-1:0] N_DIV2 = 1;

  logic           sc_q, sl_q;
  logic [PAY-1:0] sr, sr_nxt;
  logic [M_W-1:0] m_nxt;
  logic [N_W-1:0] n_nxt;
  logic           ssc_nxt;

  wire shift_en = s_clk & ~sc_q & p_load_n;
  wire sl_rise  = s_load & ~sl_q;
  wire pass     = s_load & sl_q & shift_en;

  assign sr_nxt = shift_en ? {sr[PAY-2:0], s_data} : sr;

  always_comb begin
    m_nxt   = m_val;
    n_nxt   = n_sel;
    ssc_nxt = ssc_en;
    if (!p_load_n) begin
      m_nxt = m_pins;
      n_nxt = N_DIV2;
    end else if (sl_rise || pass) begin
      ssc_nxt = sr_nxt[PAY-1];
      n_nxt   = sr_nxt[M_W +: N_W];
      m_nxt   = sr_nxt[M_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_q    <= 1'b0;
      sl_q    <= 1'b0;
      sr      <= '0;
      m_val   <= M_INIT;
      n_sel   <= N_DIV2;
      ssc_en  <= 1'b0;
      div_en  <= 1'b0;
      cfg_upd <= 1'b0;
    end else begin
      sc_q    <= s_clk;
      sl_q    <= s_load;
      sr      <= sr_nxt;
      m_val   <= m_nxt;
      n_sel   <= n_nxt;
      ssc_en  <= ssc_nxt;
      div_en  <= ~mr;
      cfg_upd <= {m_nxt, n_nxt, ssc_nxt} != {m_val, n_sel, ssc_en};
    end
  end
endmodule

// File: rtl/synth_cfg_loader_chk.sv
module synth_cfg_loader_chk #(
  parameter int M_W = 9,
  parameter int N_W = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mr,
  input logic           p_load_n,
  input logic [M_W-1:0] m_pins,
  input logic           s_load,
  input logic [M_W-1:0] m_val,
  input logic [N_W-1:0] n_sel,
  input logic           ssc_en,
  input logic           div_en,
  input logic           cfg_upd
);
  assert_reset_vals_R1: assert property (@(posedge clk)
    !rst_n |=> (n_sel == 2'b01 && !ssc_en && !cfg_upd && !div_en));

  assert_parallel_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !p_load_n |=> (m_val == $past(m_pins) && n_sel == 2'b01));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (p_load_n && !s_load) |=> ($stable(m_val) && $stable(n_sel) && $stable(ssc_en)));

  assert_div_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mr |=> !div_en);

  assert_div_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mr |=> div_en);

  assert_upd_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_upd |-> ({m_val, n_sel, ssc_en} != $past({m_val, n_sel, ssc_en})));

  assert_upd_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_upd |-> ($stable(m_val) && $stable(n_sel) && $stable(ssc_en)));
endmodule

bind synth_cfg_loader synth_cfg_loader_chk u_chk (.*);

// File: tb/sim_synth_cfg_loader.sv
module sim_synth_cfg_loader;
  logic clk = 0, rst_n = 0, mr = 0, p_load_n = 1, s_clk = 0, s_data = 0, s_load = 0;
  logic [8:0] m_pins = '0;
  logic [8:0] m_val;
  logic [1:0] n_sel;
  logic ssc_en, div_en, cfg_upd;

  always #4 clk = ~clk;

  synth_cfg_loader u0 (.clk(clk), .rst_n(rst_n), .mr(mr), .p_load_n(p_load_n),
    .m_pins(m_pins), .s_clk(s_clk), .s_data(s_data), .s_load(s_load),
    .m_val(m_val), .n_sel(n_sel), .ssc_en(ssc_en), .div_en(div_en), .cfg_upd(cfg_upd));

  typedef struct { logic [8:0] m; logic [1:0] n; logic s; logic d; logic u; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;

  logic [8:0]  bm = 9'd200;
  logic [1:0]  bn = 2'b01;
  logic        bs = 0, bd = 0, psc = 0, psl = 0;
  logic [11:0] bsr = '0;

  task automatic push_exp(input string tag);
    logic [11:0] srn;
    logic [8:0] nm; logic [1:0] nn; logic ns;
    logic sh;
    exp_t e;
    sh  = s_clk & ~psc & p_load_n;
    srn = sh ? {bsr[10:0], s_data} : bsr;
    nm = bm; nn = bn; ns = bs;
    if (!p_load_n) begin nm = m_pins; nn = 2'b01; end
    else if ((s_load && !psl) || (s_load && psl && sh)) begin
      ns = srn[11]; nn = srn[10:9]; nm = srn[8:0];
    end
    e.u = {nm, nn, ns} != {bm, bn, bs};
    bm = nm; bn = nn; bs = ns; bd = ~mr; bsr = srn; psc = s_clk; psl = s_load;
    e.m = bm; e.n = bn; e.s = bs; e.d = bd; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic drive(input logic pl, input logic [8:0] pins, input logic sc, input logic sd,
                       input logic sl, input logic mri, input string tag);
    @(negedge clk);
    p_load_n = pl; m_pins = pins; s_clk = sc; s_data = sd; s_load = sl; mr = mri;
    push_exp(tag);
  endtask

  task automatic send_frame(input logic ssc, input logic [1:0] n, input logic [8:0] m,
                            input logic coincide, input string tag);
    logic [13:0] f;
    f = {2'b00, ssc, n, m};
    for (int i = 13; i >= 0; i--) begin
      drive(1, m_pins, 0, f[i], 0, 0, tag);
      drive(1, m_pins, 1, f[i], (coincide && i == 0), 0, tag);
    end
    if (!coincide) drive(1, m_pins, 0, 0, 1, 0, tag);
    drive(1, m_pins, 0, 0, 0, 0, tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (m_val !== e.m || n_sel !== e.n || ssc_en !== e.s || div_en !== e.d || cfg_upd !== e.u) begin
        fails++;
        $display("FAIL %s: got m=%h n=%b s=%b d=%b u=%b expected m=%h n=%b s=%b d=%b u=%b",
          e.tag, m_val, n_sel, ssc_en, div_en, cfg_upd, e.m, e.n, e.s, e.d, e.u);
      end
    end
  end

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (m_val !== 9'd200 || n_sel !== 2'b01 || ssc_en !== 0 || div_en !== 0 || cfg_upd !== 0) begin
      fails++;
      $display("FAIL R1: got m=%h n=%b s=%b d=%b u=%b expected m=0c8 n=01 s=0 d=0 u=0",
        m_val, n_sel, ssc_en, div_en, cfg_upd);
    end
    @(negedge clk);
    rst_n = 1;
    push_exp("R1");
    drive(1, 0, 0, 0, 0, 0, "R1");
    // R2: parallel pass-through with several pin patterns
    drive(0, 9'h0AB, 0, 0, 0, 0, "R2");
    drive(0, 9'h155, 0, 0, 0, 0, "R2");
    drive(0, 9'h1FF, 0, 0, 0, 0, "R2");
    drive(0, 9'h07D, 0, 0, 0, 0, "R2");
    // R3: latched after strobe rises
    drive(1, 9'h07D, 0, 0, 0, 0, "R3");
    drive(1, 9'h100, 0, 0, 0, 0, "R3");
    drive(1, 9'h0F0, 0, 0, 0, 0, "R3");
    // R4 R5 R6 R8: frames with separate transfer strobe, all four select codes
    send_frame(1, 2'b10, 9'h155, 0, "R4_R5_R6_R8");
    send_frame(0, 2'b00, 9'h0AA, 0, "R8");
    send_frame(1, 2'b11, 9'h15E, 0, "R8");
    // R6: shifting with strobe low after a fall keeps outputs
    for (int i = 0; i < 5; i++) begin
      drive(1, 9'h0F0, 0, 1, 0, 0, "R6");
      drive(1, 9'h0F0, 1, 1, 0, 0, "R6");
    end
    // R5: last shift edge coincides with strobe rise
    send_frame(0, 2'b01, 9'h0C3, 1, "R5");
    // R7: strobe held high, every shift edge passes through
    drive(1, 9'h0F0, 0, 0, 1, 0, "R7");
    for (int i = 0; i < 12; i++) begin
      drive(1, 9'h0F0, 0, i[0], 1, 0, "R7");
      drive(1, 9'h0F0, 1, i[0], 1, 0, "R7");
    end
    drive(1, 9'h0F0, 0, 0, 0, 0, "R7");
    // R9: master reset only affects divider enable
    drive(1, 9'h0F0, 0, 0, 0, 1, "R9");
    drive(1, 9'h0F0, 0, 0, 0, 1, "R9");
    drive(1, 9'h0F0, 0, 0, 0, 0, "R9");
    // R11: shift edges during parallel mode are ignored
    send_frame(1, 2'b10, 9'h033, 0, "R11");
    drive(0, 9'h011, 0, 0, 0, 0, "R11");
    for (int i = 0; i < 6; i++) begin
      drive(0, 9'h011, 0, 1, 0, 0, "R11");
      drive(0, 9'h011, 1, 1, 0, 0, "R11");
    end
    drive(1, 9'h011, 0, 0, 0, 0, "R11");
    drive(1, 9'h011, 0, 0, 1, 0, "R11");
    drive(1, 9'h011, 0, 0, 0, 0, "R10");
    drive(1, 9'h011, 0, 0, 0, 0, "R10");
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule